// File: doc/BRIEF.md
# Masked Interrupt Flag Register

This block holds the pending interrupt requests of a small microcontroller core. It has two sources. The first is a single-cycle overflow pulse from the timer. The second is an input-change detector on the 8-bit general-purpose port. The detector passes the port pins through a synchronizer. It then compares the synchronized value against a reference that is captured each time software reads the port. Each source has its own flag bit and its own mask bit.

The core reaches the block through a small register port with two addresses: one for the flag register and one for the mask register. A write can only clear flags, never set them. A flag read returns the flags ANDed with the mask. Two instruction strobes turn the global interrupt enable on and off. The interrupt request to the core is any masked pending flag, qualified by the global enable. The wake-up output for sleep mode is the same condition without the global enable.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, the flag register, the mask register and the global enable are all zero, so both register reads return 0 and `irqOut` and `wakeOut` are low.
- R2: A `tmrOvf` pulse sampled on a clock edge sets flag bit 0 (timer) from the next cycle on.
- R3: A write to address 0 (flag register) clears each flag bit whose written bit is 0 and leaves each flag bit whose written bit is 1 unchanged, so a write never sets a flag.
- R4: When a source event and a clearing write to its flag bit arrive in the same cycle, the flag ends up set.
- R5: A read of address 0 returns (flags AND mask) in bits [1:0]. A read of address 1 returns the mask in bits [1:0]. Bits above 1 read as 0, and written upper bits are discarded.
- R6: When the synchronized port value differs from the stored reference, flag bit 1 (port change) is set. A new pin value reaches the flag no later than 3 clock edges after it is applied.
- R7: A `portRd` strobe latches the current synchronized port value as the new reference. While the pins then stay equal to that reference, flag bit 1 stays clear once it has been cleared. The flag sets again when the pins move away from the reference.
- R8: `intEnable` sets the global enable and `intDisable` clears it, and disable wins when both arrive together. `irqOut` is high exactly when the global enable is set and at least one flag bit is set with its mask bit set.
- R9: `wakeOut` is high whenever at least one flag bit is set with its mask bit set, whatever the state of the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrOvf | input | 1 | Timer overflow event pulse |
| portIn | input | PORT_W | Raw port pins watched for changes |
| portRd | input | 1 | Software read of the port; latches the change reference |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 flags, 1 mask |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| intEnable | input | 1 | Global interrupt enable instruction strobe |
| intDisable | input | 1 | Global interrupt disable instruction strobe |
| irqOut | output | 1 | Interrupt request to the core |
| wakeOut | output | 1 | Wake-up request for sleep mode |

## Verification
The bench builds the block with the default values: an 8-bit port, an 8-bit register bus and a two-stage synchronizer. With these values the discarded upper write bits are exercised, and so is a change on a high port pin. The two-stage synchronizer also fixes the three-edge latency from a pin change to the flag, which the bench waits out before each port check. Same-cycle races are driven on purpose: a clearing write against a timer pulse, and the enable strobe against the disable strobe.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NUM_SRC = 2;
  localparam int IDX_TMR = 0;
  localparam int IDX_CHG = 1;

  typedef struct packed {
    logic wrFlag;
    logic wrMask;
    logic latchRef;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      regAddr,
  input  logic      portRd,
  input  logic      intEnable,
  input  logic      intDisable,
  output ctrlStrb_t strb,
  output logic      gieQ
);
  always_comb begin
    strb.wrFlag   = regWrEn && !regAddr;
    strb.wrMask   = regWrEn && regAddr;
    strb.latchRef = portRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           gieQ <= 1'b0;
    else if (intDisable) gieQ <= 1'b0;
    else if (intEnable)  gieQ <= 1'b1;
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               rdAddr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               tmrOvf,
  input  logic [PORT_W-1:0]  portIn,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData
);
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] refQ;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] keepMask;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= portIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              refQ <= '0;
    else if (strb.latchRef) refQ <= syncQ[SYNC_STAGES-1];
  end

  always_comb begin
    evt          = '0;
    evt[IDX_TMR] = tmrOvf;
    evt[IDX_CHG] = (syncQ[SYNC_STAGES-1] != refQ) && !strb.latchRef;
    keepMask     = strb.wrFlag ? wrData : '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= (flagQ & keepMask) | evt;
      if (strb.wrMask) maskQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[NUM_SRC-1:0] = rdAddr ? maskQ : (flagQ & maskQ);
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic [PORT_W-1:0] portIn,
  input  logic              portRd,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              intEnable,
  input  logic              intDisable,
  output logic              irqOut,
  output logic              wakeOut
);
  ctrlStrb_t          strb;
  logic               gieQ;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               unusedBits;

  assign unusedBits = ^regWrData[DATA_W-1:NUM_SRC];

  irq_flag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .portRd(portRd), .intEnable(intEnable), .intDisable(intDisable),
    .strb(strb), .gieQ(gieQ)
  );

  irq_flag_dp #(.PORT_W(PORT_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(regAddr),
    .wrData(regWrData[NUM_SRC-1:0]), .tmrOvf(tmrOvf), .portIn(portIn),
    .flagQ(flagQ), .maskQ(maskQ), .rdData(regRdData)
  );

  assign wakeOut = |(flagQ & maskQ);
  assign irqOut  = gieQ && wakeOut;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_flag_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tmrOvf,
  input logic               regWrEn,
  input logic               regAddr,
  input logic               wrBit0,
  input logic               intEnable,
  input logic               intDisable,
  input logic               irqOut,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] flagQ,
  input logic               gieQ
);
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrOvf && !flagQ[IDX_TMR]) |=> !flagQ[IDX_TMR]); // R3
  AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> flagQ[IDX_TMR]); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr && !wrBit0 && !tmrOvf) |=> !flagQ[IDX_TMR]); // R3
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |=> !gieQ); // R8
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable && !intDisable) |=> gieQ); // R8
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    !gieQ |-> !irqOut); // R8
  AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> wakeOut); // R9
endmodule

bind irq_flag_unit irq_flag_chk chk_i (
  .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .regWrEn(regWrEn),
  .regAddr(regAddr), .wrBit0(regWrData[0]), .intEnable(intEnable),
  .intDisable(intDisable), .irqOut(irqOut), .wakeOut(wakeOut),
  .flagQ(flagQ), .gieQ(gieQ)
);

// File: tb/irq_flag_unit_tb_top.sv
`timescale 1ns/1ps
module irq_flag_unit_tb_top;
  localparam int PORT_W = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tmrOvf = 1'b0;
  logic [PORT_W-1:0] portIn = '0;
  logic portRd = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic intEnable = 1'b0;
  logic intDisable = 1'b0;
  logic irqOut, wakeOut;

  always #5 clk = ~clk;

  irq_flag_unit #(.PORT_W(PORT_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .portIn(portIn), .portRd(portRd),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .intEnable(intEnable), .intDisable(intDisable),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  typedef struct {
    string       tag;
    logic [9:0]  expVal;
  } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Select a register and queue the expected {rdData, irq, wake} for the monitor.
  task automatic expectRd(input logic addr, input logic [7:0] data,
                          input logic irq, input logic wake, input string tag);
    item_t it;
    regAddr = addr;
    it.tag = tag;
    it.expVal = {data, irq, wake};
    scoreQ.push_back(it);
    step();
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      logic [9:0] act;
      it = scoreQ.pop_front();
      act = {regRdData, irqOut, wakeOut};
      checks++;
      if (act !== it.expVal) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.expVal);
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    expectRd(1'b0, 8'h00, 0, 0, "R1 flags after reset");
    expectRd(1'b1, 8'h00, 0, 0, "R1 mask after reset");

    writeReg(1'b1, 8'hFF);
    expectRd(1'b1, 8'h03, 0, 0, "R5 mask read drops upper bits");

    tmrOvf = 1'b1; step(); tmrOvf = 1'b0;
    expectRd(1'b0, 8'h01, 0, 1, "R2 timer sets flag, R9 wake without gie");

    intEnable = 1'b1; step(); intEnable = 1'b0;
    expectRd(1'b0, 8'h01, 1, 1, "R8 irq after enable");

    writeReg(1'b0, 8'hFF);
    expectRd(1'b0, 8'h01, 1, 1, "R3 write of ones keeps flag");
    writeReg(1'b0, 8'hFE);
    expectRd(1'b0, 8'h00, 0, 0, "R3 write of zero clears flag");
    writeReg(1'b0, 8'hFF);
    expectRd(1'b0, 8'h00, 0, 0, "R3 write cannot set flag");

    tmrOvf = 1'b1; regWrEn = 1'b1; regAddr = 1'b0; regWrData = 8'h00;
    step();
    tmrOvf = 1'b0; regWrEn = 1'b0;
    expectRd(1'b0, 8'h01, 1, 1, "R4 event beats clear");

    writeReg(1'b1, 8'h02);
    expectRd(1'b0, 8'h00, 0, 0, "R5 masked flag reads zero");
    writeReg(1'b1, 8'h03);
    expectRd(1'b0, 8'h01, 1, 1, "R5 flag kept under mask");
    writeReg(1'b0, 8'h00);

    portIn = 8'h10;
    step(4);
    expectRd(1'b0, 8'h02, 1, 1, "R6 port change sets flag");

    portRd = 1'b1; step(); portRd = 1'b0;
    writeReg(1'b0, 8'h00);
    step(4);
    expectRd(1'b0, 8'h00, 0, 0, "R7 no change after reference latch");

    portIn = 8'h11;
    step(4);
    expectRd(1'b0, 8'h02, 1, 1, "R7 new change detected");

    intDisable = 1'b1; step(); intDisable = 1'b0;
    expectRd(1'b0, 8'h02, 0, 1, "R8 disable drops irq, R9 wake stays");

    intEnable = 1'b1; step(); intEnable = 1'b0;
    intEnable = 1'b1; intDisable = 1'b1; step();
    intEnable = 1'b0; intDisable = 1'b0;
    expectRd(1'b0, 8'h02, 0, 1, "R8 disable wins over enable");

    step(2);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule